// File: doc/BRIEF.md
# Saturating Ones-Count Window Network

The block reports, for every position of an input vector, whether the number of ones seen from the first bit up to and including that position is exactly one or two. It is built as a chain of identical cells. Each cell takes one input bit and a two-bit count from its left neighbour, and passes an updated count to the right. The count saturates once three ones have been seen, so any ones after that point do not change it.

The same cell also serves as the next-state logic of a clocked serial form. That form takes one bit per accepted cycle and gives the same output sequence the spatial chain gives across its positions. A synchronous clear restarts the serial count. Both forms sit side by side in one top module, so a spatial result can be checked against a serial run over the same bits.

Top module: `ones_win_top`

## Requirements
- R1: For every position k (bit 0 is the first cell), `win_o[k]` is 1 exactly when `vec_i[0]` through `vec_i[k]` hold one or two ones.
- R2: The first cell starts from the zero count, so `win_o[0]` equals `vec_i[0]`.
- R3: The count between cells is encoded as 00 = zero, 01 = one, 10 = two and 11 = three or more. Once it reaches 11 it stays there, and every later output is 0 whatever the later bits are.
- R4: On a clock edge with `bit_vld_i` high and `clr_i` low, the serial count takes in `bit_i`. From the next cycle on, `bit_win_o` is 1 exactly when the bits taken in since the last clear or reset hold one or two ones.
- R5: On an edge with `bit_vld_i` low and `clr_i` low, the serial count and `bit_win_o` keep their values, and `bit_i` has no effect.
- R6: On an edge with `clr_i` high, the serial count returns to zero and `bit_win_o` becomes 0. This holds even when `bit_vld_i` and `bit_i` are high on that edge, and the bit is then not counted.
- R7: While `rst_ni` is low, the serial count is zero and `bit_win_o` is 0, without waiting for a clock edge.
- R8: Feeding `vec_i[0]` through `vec_i[N-1]` into the serial form, in that order, after a clear gives the sequence `win_o[0]` through `win_o[N-1]` on `bit_win_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the serial form |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vec_i | input | N | Input bits of the spatial chain; bit 0 feeds the first cell |
| win_o | output | N | Per-position window flags of the spatial chain |
| clr_i | input | 1 | Synchronous clear of the serial count |
| bit_vld_i | input | 1 | Accepts `bit_i` on this edge |
| bit_i | input | 1 | Serial input bit |
| bit_win_o | output | 1 | Registered window flag of the serial form |

## Verification
The case that is hardest to reach is the saturated count followed by more ones. The output has to stay low there, while a counter that wrapped would show a false one-or-two window. The stimulus reaches it with all-ones and dense vectors, and with long serial runs that keep feeding ones after the third. Gaps with `bit_vld_i` low and a clear raised together with a valid one bit check the hold and clear priority, and every serial run is compared against the spatial flags of the same vector.

// File: rtl/ones_win_pkg.sv
package ones_win_pkg;
  typedef enum logic [1:0] {
    CNT_ZERO = 2'b00,
    CNT_ONE  = 2'b01,
    CNT_TWO  = 2'b10,
    CNT_SAT  = 2'b11
  } cnt_e;
endpackage

// File: rtl/ones_win_cell.sv
module ones_win_cell
  import ones_win_pkg::*;
(
  input  cnt_e c_i,
  input  logic x_i,
  output cnt_e c_o,
  output logic z_o
);
  always_comb begin
    unique case (c_i)
      CNT_ZERO: c_o = x_i ? CNT_ONE : CNT_ZERO;
      CNT_ONE:  c_o = x_i ? CNT_TWO : CNT_ONE;
      CNT_TWO:  c_o = x_i ? CNT_SAT : CNT_TWO;
      default:  c_o = CNT_SAT;
    endcase
  end

  // flag taken from the outgoing count, after x_i is counted
  assign z_o = (c_o == CNT_ONE) || (c_o == CNT_TWO);
endmodule

// File: rtl/ones_win_array.sv
module ones_win_array
  import ones_win_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] win_o
);
  cnt_e chain [N+1];

  assign chain[0] = CNT_ZERO;

  for (genvar k = 0; k < N; k++) begin : g_cell
    ones_win_cell u_cell (
      .c_i(chain[k]),
      .x_i(vec_i[k]),
      .c_o(chain[k+1]),
      .z_o(win_o[k])
    );
  end
endmodule

// File: rtl/ones_win_serial.sv
module ones_win_serial
  import ones_win_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic z_o
);
  cnt_e cnt_q, cnt_d;
  logic z_d, z_q;

  ones_win_cell u_cell (
    .c_i(cnt_q),
    .x_i(bit_i),
    .c_o(cnt_d),
    .z_o(z_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_ZERO;
      z_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= CNT_ZERO;
      z_q   <= 1'b0;
    end else if (vld_i) begin
      cnt_q <= cnt_d;
      z_q   <= z_d;
    end
  end

  assign z_o = z_q;

  assert_sat_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_SAT && !clr_i) |=> (cnt_q == CNT_SAT && !z_q));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i) |=> (z_q == (cnt_q == CNT_ONE || cnt_q == CNT_TWO)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> ($stable(cnt_q) && $stable(z_q)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == CNT_ZERO && !z_q));
endmodule

// File: rtl/ones_win_top.sv
module ones_win_top #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] win_o,
  input  logic         clr_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic         bit_win_o
);
  ones_win_array #(.N(N)) u_array (
    .vec_i(vec_i),
    .win_o(win_o)
  );

  ones_win_serial u_serial (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .vld_i (bit_vld_i),
    .bit_i (bit_i),
    .z_o   (bit_win_o)
  );

  assert_last_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_o[N-1] == ($countones(vec_i) inside {1, 2}));

  assert_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_o[0] == vec_i[0]);
endmodule

// File: tb/tb_ones_win_top.sv
`timescale 1ns/1ps
module tb_ones_win_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] vec_i = '0;
  logic [N-1:0] win_o;
  logic         clr_i = 1'b0;
  logic         bit_vld_i = 1'b0;
  logic         bit_i = 1'b0;
  logic         bit_win_o;

  int total = 0;
  int bad = 0;
  int ref_cnt = 0;
  logic ref_z = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ones_win_top #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .vec_i(vec_i), .win_o(win_o),
    .clr_i(clr_i), .bit_vld_i(bit_vld_i), .bit_i(bit_i), .bit_win_o(bit_win_o)
  );

  function automatic logic [N-1:0] ref_win(input logic [N-1:0] v);
    int c = 0;
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      if (v[k]) c++;
      r[k] = (c == 1 || c == 2);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic spatial(input logic [N-1:0] v);
    vec_i = v;
    #1;
    chk("R1", win_o, ref_win(v));
    chk("R2", {{(N-1){1'b0}}, win_o[0]}, {{(N-1){1'b0}}, v[0]});
  endtask

  // inputs driven after negedge, result checked at following negedge
  task automatic step(input logic c, input logic v, input logic b, input string req);
    clr_i = c; bit_vld_i = v; bit_i = b;
    @(posedge clk);
    if (c) begin ref_cnt = 0; ref_z = 1'b0; end
    else if (v) begin
      if (b && ref_cnt < 3) ref_cnt++;
      ref_z = (ref_cnt == 1 || ref_cnt == 2);
    end
    @(negedge clk);
    clr_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    chk(req, {{(N-1){1'b0}}, bit_win_o}, {{(N-1){1'b0}}, ref_z});
  endtask

  task automatic serial_run(input logic [N-1:0] v, input bit gaps);
    logic [N-1:0] exp_w;
    spatial(v);
    exp_w = win_o;
    step(1'b1, 1'b0, 1'b0, "R6");
    for (int k = 0; k < N; k++) begin
      step(1'b0, 1'b1, v[k], "R4");
      chk("R8", {{(N-1){1'b0}}, bit_win_o}, {{(N-1){1'b0}}, exp_w[k]});
      if (gaps && (k % 3 == 1)) step(1'b0, 1'b0, 1'b1, "R5");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R7", {{(N-1){1'b0}}, bit_win_o}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7", {{(N-1){1'b0}}, bit_win_o}, '0);

    spatial('0);
    spatial('1);                       // R3 saturation: 00000011
    chk("R3", win_o, 8'b0000_0011);
    spatial(8'h01);
    spatial(8'h80);
    spatial(8'hA5);
    spatial(8'h18);
    spatial(8'h0E);
    chk("R3", win_o, 8'b0000_0110);
    for (int i = 0; i < 20; i++) spatial(N'($urandom));

    serial_run(8'hFF, 1'b0);
    serial_run(8'h90, 1'b1);
    serial_run(8'h4B, 1'b1);
    for (int i = 0; i < 10; i++) serial_run(N'($urandom), i[0]);

    // long saturated run keeps flag low (R3)
    step(1'b1, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 1'b1, "R3");

    // clear wins over a valid one bit (R6)
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b1, "R4");
    step(1'b0, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");

    // async reset mid-run (R7)
    step(1'b0, 1'b1, 1'b1, "R4");
    #1 rst_ni = 1'b0;
    #1 chk("R7", {{(N-1){1'b0}}, bit_win_o}, '0);
    ref_cnt = 0; ref_z = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, 1'b1, "R7");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule